// File: doc/BRIEF.md
# Timer-Triggered Parallel Pulse Output

This block drives a bank of parallel output pins from a port output register that changes only at timer events. Each of one or more 16-bit up-counters runs while its start bit is set. When a counter equals its period register it returns to zero and produces a one-cycle match event. Software keeps a pending pattern in a next-data register. At a match event the bits that are enabled and belong to a group listening to that counter move from next-data into the output register together, so several phases switch on the same clock edge with no glitch.

The output bits form groups of four. A 2-bit select field per group names the counter whose match moves that group. Every match also sets a per-channel flag, which raises an interrupt when enabled. The interrupt handler clears the flag and loads the next pattern one period before it is needed. This gives overlapping multi-phase sequences such as the five-phase step pattern. Bits outside the enable mask are ordinary port bits that software writes directly.

Top module: `tpo_unit`

## Requirements
- R1: While running, counter c counts 0,1,...,PER and returns to 0 on the edge after it equals PER, so consecutive match events on one channel are PER+1 cycles apart.
- R2: A counter whose start bit (register 0, bit c) is 0 holds its value and produces no match.
- R3: A match sets flag c (register 2, bit c). A write to register 2 clears every flag whose bit is written as 0 and leaves those written as 1 alone. A match in the same cycle as a clearing write leaves the flag set.
- R4: irq[c] is high exactly while flag c and interrupt enable c (register 1, bit c) are both 1.
- R5: On the edge that ends a match cycle, every output bit that is enabled (register 3) and whose group is triggered takes the next-data value (register 5).
- R6: Output bits not moved by a trigger keep their value. A write to the output register (register 6) sets all bits, and a trigger in the same cycle overrides the bits it moves.
- R7: Group g (output bits 4g+3..4g) uses trigger select bits 2g+1..2g of register 4. A code c below the channel count selects channel c. Any other code never triggers that group.
- R8: A next-data write in the same cycle as a trigger does not affect that transfer. The new value goes out at the following trigger.
- R9: After reset the outputs, flags, enables, selects, next-data and counters are 0, no counter runs, and every period register is 0xFFFF.
- R10: Period register c sits at address 8+c and counter c reads back at address 12+c. Reads are combinational on addr.
- R11: With the upper five bits enabled, preloading 0x80 and reloading 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88, 0x80 at successive interrupts reproduces that sequence on the upper five pins, one step per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr |
| pulse_out | output | OUT_W | Port output register |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The assertions assume that software writes a period register only while that counter is stopped or still below the new value, so that a counter never runs past its period. The bench keeps to this rule: it changes periods and selects only while the counters are stopped. It lines up same-cycle writes by polling a counter readback until the counter equals its period, then drives the write in that same cycle. Tests that stress a collision run with the interrupt enable cleared, so no handler write can land on a trigger edge by accident.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_START    = 4'd0;
   localparam logic [ADDR_W-1:0] A_IEN      = 4'd1;
   localparam logic [ADDR_W-1:0] A_FLAG     = 4'd2;
   localparam logic [ADDR_W-1:0] A_NDER     = 4'd3;
   localparam logic [ADDR_W-1:0] A_TSEL     = 4'd4;
   localparam logic [ADDR_W-1:0] A_NDR      = 4'd5;
   localparam logic [ADDR_W-1:0] A_OUT      = 4'd6;
   localparam logic [ADDR_W-1:0] A_PER_BASE = 4'd8;
   localparam logic [ADDR_W-1:0] A_CNT_BASE = 4'd12;
   localparam int MAX_CH = 4;
endpackage

// File: rtl/tpo_timer.sv
module tpo_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);
   if (CNT_W < 2) begin : g_bad_w
      $error("tpo_timer: CNT_W too small");
   end

   assign match = run && (cnt == period);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (match)  cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
   end

   // R1: a match returns the counter to zero
   a_r1_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (cnt == '0));

   // R2: a stopped counter holds
   a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));
endmodule

// File: rtl/tpo_trigsel.sv
module tpo_trigsel #(
   parameter int OUT_W = 8,
   parameter int GRP_W = 4,
   parameter int NCH   = 2,
   parameter int SEL_W = 2,
   localparam int NGRP   = OUT_W / GRP_W,
   localparam int TSEL_W = NGRP * SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TSEL_W-1:0] tsel,
   input  logic [NCH-1:0]    match,
   input  logic [OUT_W-1:0]  nder,
   output logic [OUT_W-1:0]  mask
);
   logic [NGRP-1:0] grp_trig;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [SEL_W-1:0] code;
      logic             hit;
      assign code = tsel[g*SEL_W +: SEL_W];
      always_comb begin
         hit = 1'b0;
         for (int c = 0; c < NCH; c++) begin
            if (code == SEL_W'(c)) hit = match[c];
         end
      end
      assign grp_trig[g] = hit;

      // R7: a code naming no channel never triggers the group
      a_r7_unused_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(code) >= NCH) |-> !grp_trig[g]);
   end

   for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      assign mask[i] = grp_trig[i / GRP_W] & nder[i];
   end
endmodule

// File: rtl/tpo_outbuf.sv
module tpo_outbuf #(
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W-1:0] ndr,
   input  logic [OUT_W-1:0] mask,
   input  logic             wr_out,
   input  logic [OUT_W-1:0] wr_val,
   output logic [OUT_W-1:0] pins
);
   logic [OUT_W-1:0] nxt;

   always_comb begin
      nxt = wr_out ? wr_val : pins;
      nxt = (nxt & ~mask) | (ndr & mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pins <= '0;
      else        pins <= nxt;
   end

   // R5: moved bits take the pending data
   a_r5_moved_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (mask != '0) |=> (((pins ^ $past(ndr)) & $past(mask)) == '0));

   // R6: without a direct write, unmoved bits hold
   a_r6_unmoved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> (((pins ^ $past(pins)) & ~$past(mask)) == '0));
endmodule

// File: rtl/tpo_unit.sv
module tpo_unit
   import tpo_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int OUT_W  = 8,
   parameter int GRP_W  = 4,
   parameter int NCH    = 2,
   parameter int SEL_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [OUT_W-1:0]  pulse_out,
   output logic [NCH-1:0]    irq
);
   localparam int NGRP   = OUT_W / GRP_W;
   localparam int TSEL_W = NGRP * SEL_W;

   if (OUT_W % GRP_W != 0) begin : g_bad_grp
      $error("tpo_unit: OUT_W must be a multiple of GRP_W");
   end
   if (NCH < 1 || NCH > MAX_CH || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("tpo_unit: NCH out of range");
   end
   if (DATA_W < CNT_W || DATA_W < OUT_W || DATA_W < TSEL_W) begin : g_bad_data
      $error("tpo_unit: DATA_W too narrow");
   end

   logic [NCH-1:0]    start_q, ien_q, flag_q, match_v, flag_keep;
   logic [OUT_W-1:0]  nder_q, ndr_q, mask;
   logic [TSEL_W-1:0] tsel_q;
   logic [CNT_W-1:0]  per_q [NCH];
   logic [CNT_W-1:0]  cnt_v [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) per_q[c] <= '1;
         else if (wr_en && addr == A_PER_BASE + 4'(c)) per_q[c] <= wdata[CNT_W-1:0];
      end
      tpo_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .run(start_q[c]), .period(per_q[c]),
         .cnt(cnt_v[c]), .match(match_v[c]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         ien_q   <= '0;
         nder_q  <= '0;
         tsel_q  <= '0;
         ndr_q   <= '0;
      end else if (wr_en) begin
         case (addr)
            A_START: start_q <= wdata[NCH-1:0];
            A_IEN:   ien_q   <= wdata[NCH-1:0];
            A_NDER:  nder_q  <= wdata[OUT_W-1:0];
            A_TSEL:  tsel_q  <= wdata[TSEL_W-1:0];
            A_NDR:   ndr_q   <= wdata[OUT_W-1:0];
            default: ;
         endcase
      end
   end

   assign flag_keep = (wr_en && addr == A_FLAG) ? wdata[NCH-1:0] : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & flag_keep) | match_v;
   end

   assign irq = flag_q & ien_q;

   tpo_trigsel #(.OUT_W(OUT_W), .GRP_W(GRP_W), .NCH(NCH), .SEL_W(SEL_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .tsel(tsel_q), .match(match_v),
      .nder(nder_q), .mask(mask));

   tpo_outbuf #(.OUT_W(OUT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .ndr(ndr_q), .mask(mask),
      .wr_out(wr_en && addr == A_OUT), .wr_val(wdata[OUT_W-1:0]),
      .pins(pulse_out));

   always_comb begin
      rdata = '0;
      case (addr)
         A_START: rdata = DATA_W'(start_q);
         A_IEN:   rdata = DATA_W'(ien_q);
         A_FLAG:  rdata = DATA_W'(flag_q);
         A_NDER:  rdata = DATA_W'(nder_q);
         A_TSEL:  rdata = DATA_W'(tsel_q);
         A_NDR:   rdata = DATA_W'(ndr_q);
         A_OUT:   rdata = DATA_W'(pulse_out);
         default: begin
            for (int c = 0; c < NCH; c++) begin
               if (addr == A_PER_BASE + 4'(c)) rdata = DATA_W'(per_q[c]);
               if (addr == A_CNT_BASE + 4'(c)) rdata = DATA_W'(cnt_v[c]);
            end
         end
      endcase
   end

   // R3: a match always leaves its flag set, clearing write or not
   a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (match_v != '0) |=> ((flag_q & $past(match_v)) == $past(match_v)));

   // R3: flags only rise through a match
   a_r3_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~$past(flag_q)) != '0) |-> ($past(match_v) != '0));

   // R4: no request without an enable
   a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~ien_q) == '0) && ((irq & ~flag_q) == '0));
endmodule

// File: tb/tb_tpo_unit.sv
module tb_tpo_unit;
   localparam int DATA_W = 16;
   localparam logic [3:0] A_START = 4'd0, A_IEN = 4'd1, A_FLAG = 4'd2, A_NDER = 4'd3,
                          A_TSEL = 4'd4, A_NDR = 4'd5, A_OUT = 4'd6,
                          A_PER0 = 4'd8, A_PER1 = 4'd9, A_CNT0 = 4'd12;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0, rdata;
   logic [7:0] pulse_out;
   logic [1:0] irq;

   tpo_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                 .rdata(rdata), .pulse_out(pulse_out), .irq(irq));

   always #2 clk = ~clk;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 0, mon_on = 0;
   logic [7:0] exp_q[$];
   logic [7:0] last_out;
   int last_cyc = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic wr_now(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      logic [15:0] c;
      forever begin
         rd(A_CNT0, c);
         if (c == v) break;
         @(negedge clk);
      end
   endtask

   // scoreboard monitor: each change of the pins pops one expected pattern
   always @(negedge clk) begin
      if (mon_on && pulse_out !== last_out) begin
         if (exp_q.size() == 0) chk(1'b0, "R11 unexpected change", pulse_out, last_out);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(pulse_out == e, "R11 R5 R6 pattern", pulse_out, e);
         end
         if (last_cyc != 0) chk(cyc - last_cyc == 10, "R1 period", cyc - last_cyc, 10);
         last_cyc = cyc;
         last_out = pulse_out;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, v2;
      logic [7:0] seq [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20, 8'h30, 8'h10, 8'h18, 8'h08, 8'h88};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state, R10 address map
      rd(A_PER0, v); chk(v == 16'hFFFF, "R9 R10 period reset", v, 16'hFFFF);
      rd(A_NDER, v); chk(v == 0, "R9 enable reset", v, 0);
      rd(A_CNT0, v); chk(v == 0, "R9 counter reset", v, 0);
      chk(pulse_out == 0 && irq == 0, "R9 outputs reset", {irq, pulse_out}, 0);

      wr(A_PER0, 9); wr(A_IEN, 1); wr(A_NDER, 16'hF8); wr(A_TSEL, 0); wr(A_NDR, 16'h80);
      repeat (5) @(negedge clk);
      rd(A_CNT0, v); chk(v == 0, "R2 stopped counter", v, 0);
      chk(pulse_out == 0, "R9 no transfer before start", pulse_out, 0);

      wr(A_OUT, 16'h05);
      chk(pulse_out == 8'h05, "R6 direct write", pulse_out, 8'h05);
      last_out = 8'h05; mon_on = 1;
      exp_q.push_back(8'h85);
      wr(A_START, 1);

      // R11 five-phase run driven by an interrupt handler
      for (int i = 1; i <= 10; i++) begin
         do @(negedge clk); while (!irq[0]);
         wr(A_FLAG, 0);
         #1 chk(irq[0] == 0, "R3 R4 clear drops irq", irq[0], 0);
         wr(A_NDR, {8'h00, seq[i % 10]});
         exp_q.push_back((seq[i % 10] & 8'hF8) | 8'h05);
      end
      do @(negedge clk); while (!irq[0]);
      wr(A_FLAG, 0);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R11 all steps seen", exp_q.size(), 0);
      mon_on = 0;

      // R2: stop and hold
      wr(A_START, 0);
      rd(A_CNT0, v); repeat (5) @(negedge clk); rd(A_CNT0, v2);
      chk(v == v2, "R2 hold after stop", v2, v);

      // R4 flag without enable, R3 write of 1 keeps flag, R1 wrap
      wr(A_IEN, 0); wr(A_FLAG, 0); wr(A_START, 1);
      wait_cnt(9);
      @(negedge clk); rd(A_CNT0, v); chk(v == 0, "R1 wrap to zero", v, 0);
      rd(A_FLAG, v); chk(v[0] == 1'b1, "R3 flag set by match", v[0], 1);
      chk(irq[0] == 0, "R4 masked irq", irq[0], 0);
      wr(A_FLAG, 16'h0001);
      rd(A_FLAG, v); chk(v[0] == 1'b1, "R3 write 1 keeps flag", v[0], 1);
      wr(A_FLAG, 0);
      rd(A_FLAG, v); chk(v[0] == 1'b0, "R3 write 0 clears flag", v[0], 0);
      wait_cnt(9);
      wr_now(A_FLAG, 0);
      rd(A_FLAG, v); chk(v[0] == 1'b1, "R3 match beats clear", v[0], 1);

      // R8 next-data write on a trigger edge
      wr(A_NDR, 16'h10);
      wait_cnt(9); @(negedge clk);
      chk(pulse_out == 8'h15, "R5 transfer", pulse_out, 8'h15);
      wait_cnt(9);
      wr_now(A_NDR, 16'h20);
      chk(pulse_out == 8'h15, "R8 old data used", pulse_out, 8'h15);
      wait_cnt(9); @(negedge clk);
      chk(pulse_out == 8'h25, "R8 new data next trigger", pulse_out, 8'h25);

      // R7 per-group select
      wr(A_START, 0); wr(A_NDER, 16'hFF); wr(A_TSEL, 16'h000C); wr(A_NDR, 16'hAB);
      wr(A_START, 1); repeat (12) @(negedge clk);
      chk(pulse_out == 8'h2B, "R7 unused code blocks group 1", pulse_out, 8'h2B);
      wr(A_START, 0); wr(A_PER1, 4); wr(A_TSEL, 16'h0007); wr(A_NDR, 16'h5C);
      wr(A_START, 16'h0002); repeat (8) @(negedge clk);
      chk(pulse_out == 8'h5B, "R7 group 1 on channel 1", pulse_out, 8'h5B);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule